// File: doc/BRIEF.md
# Programmable Memory-Hole Address Decoder

This block sits in a host bridge and splits the physical address space into four regions. Low RAM runs from zero up to a programmable hole base. The 32-bit PCI hole runs from that base up to 4 GiB. RAM that the hole displaces is relocated to start at 4 GiB. A 64-bit PCI window follows that relocated RAM. The hole base is a 32-bit little-endian register on a small byte-enabled configuration port. Its upper half is writable. Its lower 16 bits always read as zero, so the base is always aligned to 64 KiB.

The region bounds are held in registers. They are recomputed every cycle from the next value of the base, the installed RAM size and the wide-addressing enable, so a configuration write is reflected in the bounds from the next clock edge on. An incoming address is sorted against these registered bounds with no clock delay. The block returns a 2-bit region code, plus a miss flag for addresses past the end of the 64-bit window.

Top module: `mhole_decoder`

## Requirements
- R1: After reset the hole base is 0xE000_0000. If `alt_default` is high during reset, the hole base is 0xF000_0000 instead.
- R2: A write whose dword address (bits 7:2 of `cfg_addr`, low two bits ignored) equals 0xB0 updates each register byte whose byte enable is set. `cfg_be[0]` selects offset 0xB0, which is bits 7:0. `cfg_be[3]` selects offset 0xB3, which is bits 31:24. A write to any other address leaves the base unchanged.
- R3: Bits 15:0 of the hole base always read as zero. Writes to offsets 0xB0 and 0xB1 have no effect.
- R4: A read of `cfg_rdata` is combinational. At dword 0xB0 it returns each register byte whose enable is set, and zero in the lanes that are not enabled. At any other address it returns zero.
- R5: `hole32_size` equals 0x1_0000_0000 minus `hole32_base`, exactly, for any 64 KiB-aligned base, including 0x8000_0000, 0xC000_0000, 0xE000_0000 and 0xF000_0000.
- R6: `hole64_base` equals 0x1_0000_0000 plus (`ram_size` minus base) when `ram_size` is at least the base. Otherwise it equals 0x1_0000_0000.
- R7: `hole64_limit` is `hole64_base` plus 2^62 when `wide_en` is high, and equals `hole64_base` (an empty window) when `wide_en` is low.
- R8: All bounds reflect a configuration write, or a change of `ram_size` or `wide_en`, from the first clock edge that samples it. They do not change before that edge.
- R9: `region` is 0 for addresses below the base, 1 for addresses from the base up to 4 GiB, 2 for addresses from 4 GiB up to `hole64_base`, and 3 for addresses from `hole64_base` up to `hole64_limit`. It responds to `addr` within the same cycle.
- R10: For an address at or above `hole64_limit`, `miss` is high and `region` is 0. Otherwise `miss` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alt_default | input | 1 | Selects the alternate reset base, 0xF000_0000 |
| wide_en | input | 1 | Enables the 64-bit PCI window |
| ram_size | input | 40 | Installed RAM size in bytes |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_be | input | 4 | Byte enables for read and write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| addr | input | 64 | Physical address to classify |
| hole32_base | output | 32 | Current hole base, which is also the top of low RAM |
| hole32_size | output | 33 | Size of the 32-bit PCI hole |
| hole64_base | output | 64 | Top of relocated RAM and start of the 64-bit window |
| hole64_limit | output | 64 | Exclusive end of the 64-bit window |
| region | output | 2 | Region code of `addr` |
| miss | output | 1 | `addr` lies beyond the 64-bit window |

## Verification
The bench probes addresses exactly at, and one below, each boundary: the base, 4 GiB, the end of relocated RAM and the window limit. An off-by-one comparison would put those addresses in the neighbouring region. It drives RAM sizes both below and above the base. A design without the clamp to zero would wrap the relocated-RAM size and place the 64-bit window far too high. Partial-lane writes, writes to the read-only low bytes, and writes to a neighbouring offset all expose a byte-order mistake or a missing address decode, because each shows up as a wrong base on read-back. Turning `wide_en` off checks that the empty window reports a miss rather than decoding as region 3.

// File: rtl/mhole_pkg.sv
package mhole_pkg;

    parameter int PHYS_W = 64;

    typedef enum logic [1:0] {
        RGN_LOW_RAM  = 2'd0,
        RGN_HOLE32   = 2'd1,
        RGN_HIGH_RAM = 2'd2,
        RGN_HOLE64   = 2'd3
    } region_e;

    typedef struct packed {
        logic [31:0]       low_top;
        logic [32:0]       size32;
        logic [PHYS_W-1:0] hole64_base;
        logic [PHYS_W-1:0] hole64_lim;
    } hole_bounds_t;

endpackage

// File: rtl/mhole_bounds_calc.sv
module mhole_bounds_calc
    import mhole_pkg::*;
#(
    parameter int RAM_W       = 40,
    parameter int HOLE64_LOG2 = 62
) (
    input  logic [31:0]      base,
    input  logic [RAM_W-1:0] ram_size,
    input  logic             wide_en,
    output hole_bounds_t     bnd
);
    localparam logic [PHYS_W-1:0] FOUR_G     = PHYS_W'(64'h1_0000_0000);
    localparam logic [PHYS_W-1:0] WIN64_SPAN = PHYS_W'(1) << HOLE64_LOG2;

    logic [PHYS_W-1:0] base_x;
    logic [PHYS_W-1:0] ram_x;
    logic [PHYS_W-1:0] reloc;

    always_comb begin
        base_x = {{(PHYS_W-32){1'b0}}, base};
        ram_x  = {{(PHYS_W-RAM_W){1'b0}}, ram_size};
        reloc  = (ram_x >= base_x) ? (ram_x - base_x) : '0;

        bnd.low_top     = base;
        bnd.size32      = 33'h1_0000_0000 - {1'b0, base};
        bnd.hole64_base = FOUR_G + reloc;
        bnd.hole64_lim  = wide_en ? (FOUR_G + reloc + WIN64_SPAN) : (FOUR_G + reloc);
    end
endmodule

// File: rtl/mhole_regs.sv
module mhole_regs
    import mhole_pkg::*;
#(
    parameter int          RAM_W       = 40,
    parameter int          HOLE64_LOG2 = 62,
    parameter int          ALIGN_LOG2  = 16,
    parameter logic [7:0]  CFG_OFFSET  = 8'hB0,
    parameter logic [31:0] DEF_BASE    = 32'hE000_0000,
    parameter logic [31:0] ALT_BASE    = 32'hF000_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alt_default,
    input  logic             wide_en,
    input  logic [RAM_W-1:0] ram_size,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_addr,
    input  logic [3:0]       cfg_be,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    output hole_bounds_t     bnd_q
);
    localparam int          LANES      = 4;
    localparam logic [31:0] ALIGN_MASK = (32'd1 << ALIGN_LOG2) - 32'd1;

    typedef struct packed {
        logic [31:0]  base;
        hole_bounds_t bnd;
    } regs_t;

    regs_t        st_d, st_q;
    hole_bounds_t bnd_next;
    logic         hit;

    assign hit = ({cfg_addr[7:2], 2'b00} == CFG_OFFSET);

    always_comb begin
        st_d.base = st_q.base;
        if (!rst_n) begin
            st_d.base = alt_default ? ALT_BASE : DEF_BASE;
        end else if (cfg_wr && hit) begin
            for (int i = 0; i < LANES; i++) begin
                if (cfg_be[i]) st_d.base[i*8 +: 8] = cfg_wdata[i*8 +: 8];
            end
        end
        st_d.base = st_d.base & ~ALIGN_MASK;
        st_d.bnd  = bnd_next;
    end

    mhole_bounds_calc #(
        .RAM_W       (RAM_W),
        .HOLE64_LOG2 (HOLE64_LOG2)
    ) u_calc (
        .base     (st_d.base),
        .ram_size (ram_size),
        .wide_en  (wide_en),
        .bnd      (bnd_next)
    );

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            cfg_rdata[i*8 +: 8] = (hit && cfg_be[i]) ? st_q.base[i*8 +: 8] : 8'h00;
        end
    end

    assign bnd_q = st_q.bnd;
endmodule

// File: rtl/mhole_classify.sv
module mhole_classify
    import mhole_pkg::*;
(
    input  logic [PHYS_W-1:0] addr,
    input  hole_bounds_t      bnd,
    output logic [1:0]        region,
    output logic              miss
);
    localparam logic [PHYS_W-1:0] FOUR_G = PHYS_W'(64'h1_0000_0000);

    region_e rgn;

    always_comb begin
        miss = 1'b0;
        rgn  = RGN_LOW_RAM;
        if (addr < {{(PHYS_W-32){1'b0}}, bnd.low_top}) begin
            rgn = RGN_LOW_RAM;
        end else if (addr < FOUR_G) begin
            rgn = RGN_HOLE32;
        end else if (addr < bnd.hole64_base) begin
            rgn = RGN_HIGH_RAM;
        end else if (addr < bnd.hole64_lim) begin
            rgn = RGN_HOLE64;
        end else begin
            miss = 1'b1;
        end
    end

    assign region = rgn;
endmodule

// File: rtl/mhole_decoder.sv
module mhole_decoder
    import mhole_pkg::*;
#(
    parameter int          RAM_W       = 40,
    parameter int          HOLE64_LOG2 = 62,
    parameter int          ALIGN_LOG2  = 16,
    parameter logic [7:0]  CFG_OFFSET  = 8'hB0,
    parameter logic [31:0] DEF_BASE    = 32'hE000_0000,
    parameter logic [31:0] ALT_BASE    = 32'hF000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alt_default,
    input  logic              wide_en,
    input  logic [RAM_W-1:0]  ram_size,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [PHYS_W-1:0] addr,
    output logic [31:0]       hole32_base,
    output logic [32:0]       hole32_size,
    output logic [PHYS_W-1:0] hole64_base,
    output logic [PHYS_W-1:0] hole64_limit,
    output logic [1:0]        region,
    output logic              miss
);
    hole_bounds_t bnd_q;

    mhole_regs #(
        .RAM_W       (RAM_W),
        .HOLE64_LOG2 (HOLE64_LOG2),
        .ALIGN_LOG2  (ALIGN_LOG2),
        .CFG_OFFSET  (CFG_OFFSET),
        .DEF_BASE    (DEF_BASE),
        .ALT_BASE    (ALT_BASE)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .alt_default (alt_default),
        .wide_en     (wide_en),
        .ram_size    (ram_size),
        .cfg_wr      (cfg_wr),
        .cfg_addr    (cfg_addr),
        .cfg_be      (cfg_be),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .bnd_q       (bnd_q)
    );

    mhole_classify u_class (
        .addr   (addr),
        .bnd    (bnd_q),
        .region (region),
        .miss   (miss)
    );

    assign hole32_base  = bnd_q.low_top;
    assign hole32_size  = bnd_q.size32;
    assign hole64_base  = bnd_q.hole64_base;
    assign hole64_limit = bnd_q.hole64_lim;
endmodule

// File: rtl/mhole_checker.sv
module mhole_checker
    import mhole_pkg::*;
#(
    parameter int RAM_W = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wide_en,
    input logic [RAM_W-1:0]  ram_size,
    input logic              cfg_wr,
    input logic [PHYS_W-1:0] addr,
    input logic [31:0]       hole32_base,
    input logic [32:0]       hole32_size,
    input logic [PHYS_W-1:0] hole64_base,
    input logic [PHYS_W-1:0] hole64_limit,
    input logic [1:0]        region,
    input logic              miss
);
    localparam logic [PHYS_W-1:0] FOUR_G = PHYS_W'(64'h1_0000_0000);

    logic seen_q;
    always_ff @(posedge clk) begin
        seen_q <= rst_n;
    end

    // R3
    base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> hole32_base[15:0] == 16'h0000);

    // R5
    hole32_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> ({1'b0, hole32_base} + hole32_size) == 33'h1_0000_0000);

    // R6
    hole64_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (hole64_base >= FOUR_G) &&
                   ((hole64_base - FOUR_G) <= {{(PHYS_W-RAM_W){1'b0}}, $past(ram_size)}));

    // R7
    hole64_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(wide_en)) |-> hole64_limit == hole64_base);

    // R8
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(cfg_wr)) |-> $stable(hole32_base));

    // R9
    low_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && region == 2'd0 && !miss) |-> addr < {{(PHYS_W-32){1'b0}}, hole32_base});

    // R10
    miss_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && miss) |-> (addr >= hole64_limit) && (region == 2'd0));
endmodule

bind mhole_decoder mhole_checker #(.RAM_W(RAM_W)) u_mhole_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .wide_en      (wide_en),
    .ram_size     (ram_size),
    .cfg_wr       (cfg_wr),
    .addr         (addr),
    .hole32_base  (hole32_base),
    .hole32_size  (hole32_size),
    .hole64_base  (hole64_base),
    .hole64_limit (hole64_limit),
    .region       (region),
    .miss         (miss)
);

// File: tb/test_mhole_decoder.sv
module test_mhole_decoder;
    localparam int RAM_W = 40;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             alt_default = 1'b0;
    logic             wide_en = 1'b1;
    logic [RAM_W-1:0] ram_size = '0;
    logic             cfg_wr = 1'b0;
    logic [7:0]       cfg_addr = 8'h00;
    logic [3:0]       cfg_be = 4'h0;
    logic [31:0]      cfg_wdata = '0;
    logic [31:0]      cfg_rdata;
    logic [63:0]      addr = '0;
    logic [31:0]      hole32_base;
    logic [32:0]      hole32_size;
    logic [63:0]      hole64_base;
    logic [63:0]      hole64_limit;
    logic [1:0]       region;
    logic             miss;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mhole_decoder i_mhole_decoder (
        .clk(clk), .rst_n(rst_n), .alt_default(alt_default), .wide_en(wide_en),
        .ram_size(ram_size), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .addr(addr),
        .hole32_base(hole32_base), .hole32_size(hole32_size),
        .hole64_base(hole64_base), .hole64_limit(hole64_limit),
        .region(region), .miss(miss)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_h64b(input logic [31:0] b, input logic [RAM_W-1:0] r);
        logic [63:0] rx = {24'h0, r};
        logic [63:0] bx = {32'h0, b};
        return 64'h1_0000_0000 + ((rx >= bx) ? rx - bx : 64'h0);
    endfunction

    function automatic logic [63:0] exp_lim(input logic [63:0] h64b, input logic w);
        return w ? h64b + (64'd1 << 62) : h64b;
    endfunction

    // returns {miss, region}
    function automatic logic [2:0] exp_cls(input logic [63:0] a, input logic [31:0] b,
                                           input logic [63:0] h64b, input logic [63:0] lim);
        if (a < {32'h0, b})           return 3'b000;
        if (a < 64'h1_0000_0000)      return 3'b001;
        if (a < h64b)                 return 3'b010;
        if (a < lim)                  return 3'b011;
        return 3'b100;
    endfunction

    task automatic cfg_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = 4'h0;
    endtask

    task automatic cfg_read(input logic [7:0] a, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_be = be;
        #1 d = cfg_rdata;
    endtask

    task automatic probe(input string tag, input logic [63:0] a, input logic [31:0] b,
                         input logic [63:0] h64b, input logic [63:0] lim);
        logic [2:0] e;
        addr = a;
        #1;
        e = exp_cls(a, b, h64b, lim);
        chk({tag, " region"}, {62'h0, region}, {62'h0, e[1:0]});
        chk({tag, " miss"}, {63'h0, miss}, {63'h0, e[2]});
    endtask

    task automatic do_reset(input logic alt);
        @(negedge clk);
        rst_n = 1'b0; alt_default = alt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] rd;
        logic [31:0] b;
        logic [63:0] h;
        logic [31:0] bases [4];
        int unused_seed;
        bases[0] = 32'hF000_0000; bases[1] = 32'hE000_0000;
        bases[2] = 32'hC000_0000; bases[3] = 32'h8000_0000;
        unused_seed = $urandom(32'd2718);

        ram_size = 40'h1_8000_0000;
        do_reset(1'b0);
        // R1 default reset base
        chk("R1 default base", {32'h0, hole32_base}, 64'hE000_0000);
        cfg_read(8'hB0, 4'hF, rd);
        chk("R4 read after reset", {32'h0, rd}, 64'hE000_0000);
        chk("R5 size after reset", {31'h0, hole32_size}, 64'h2000_0000);
        chk("R6 h64 base after reset", hole64_base, 64'h1_A000_0000);

        do_reset(1'b1);
        alt_default = 1'b0;
        // R1 alternate reset base
        chk("R1 alt base", {32'h0, hole32_base}, 64'hF000_0000);

        // R2 R3 full write: low bytes dropped; R8 takes effect after the edge
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 8'hB0; cfg_be = 4'hF; cfg_wdata = 32'hC000_1234;
        #1 chk("R8 unchanged before edge", {32'h0, hole32_base}, 64'hF000_0000);
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = 4'h0;
        chk("R8 updated after edge", {32'h0, hole32_base}, 64'hC000_0000);
        cfg_read(8'hB0, 4'hF, rd);
        chk("R3 low bytes read zero", {32'h0, rd}, 64'hC000_0000);

        // R2 single top lane
        cfg_write(8'hB0, 4'b1000, 32'h80FF_5555);
        chk("R2 lane3 write", {32'h0, hole32_base}, 64'h8000_0000);
        // R2 lane 2, low two address bits ignored
        cfg_write(8'hB3, 4'b0100, 32'h0012_0000);
        chk("R2 lane2 write", {32'h0, hole32_base}, 64'h8012_0000);
        // R3 writes to low lanes only
        cfg_write(8'hB0, 4'b0011, 32'hFFFF_FFFF);
        chk("R3 low lanes ignored", {32'h0, hole32_base}, 64'h8012_0000);
        // R2 other offset ignored
        cfg_write(8'hB4, 4'hF, 32'h1111_0000);
        chk("R2 other offset ignored", {32'h0, hole32_base}, 64'h8012_0000);
        // R4 read masking and other address
        cfg_read(8'hB0, 4'b0100, rd);
        chk("R4 masked read", {32'h0, rd}, 64'h0012_0000);
        cfg_read(8'hA0, 4'hF, rd);
        chk("R4 other addr reads zero", {32'h0, rd}, 64'h0);

        // R6 RAM smaller than base clamps; R7 window off
        ram_size = 40'h4000_0000;
        wide_en = 1'b0;
        cfg_write(8'hB0, 4'hF, 32'hE000_0000);
        chk("R6 clamp", hole64_base, 64'h1_0000_0000);
        chk("R7 empty window", hole64_limit, 64'h1_0000_0000);
        probe("R10 above 4G miss", 64'h1_0000_0000, 32'hE000_0000, 64'h1_0000_0000, 64'h1_0000_0000);
        wide_en = 1'b1;
        @(negedge clk);
        chk("R7 window on", hole64_limit, 64'h4000_0001_0000_0000);
        probe("R9 window start", 64'h1_0000_0000, 32'hE000_0000, 64'h1_0000_0000,
              64'h4000_0001_0000_0000);
        probe("R10 window end", 64'h4000_0001_0000_0000, 32'hE000_0000, 64'h1_0000_0000,
              64'h4000_0001_0000_0000);

        // R5 R6 R7 R9 R10 random and standard bases
        for (int it = 0; it < 300; it++) begin
            logic [63:0] lim;
            logic [63:0] pts [9];
            b = ($urandom_range(1) == 0) ? bases[$urandom_range(3)] : {$urandom_range(16'hFFFF, 0), 16'h0};
            if ($urandom_range(1) == 0) ram_size = {8'h0, $urandom()};
            else ram_size = {$urandom_range(255, 0), $urandom()};
            wide_en = ($urandom_range(3) != 0);
            cfg_write(8'hB0, 4'hF, b | {16'h0, $urandom_range(16'hFFFF, 0)});
            h = exp_h64b(b, ram_size);
            lim = exp_lim(h, wide_en);
            chk("R5 base", {32'h0, hole32_base}, {32'h0, b});
            chk("R5 size", {31'h0, hole32_size}, 64'h1_0000_0000 - {32'h0, b});
            chk("R6 h64 base", hole64_base, h);
            chk("R7 limit", hole64_limit, lim);
            pts[0] = {32'h0, b} - 64'd1; pts[1] = {32'h0, b};
            pts[2] = 64'hFFFF_FFFF;      pts[3] = 64'h1_0000_0000;
            pts[4] = h - 64'd1;          pts[5] = h;
            pts[6] = lim - 64'd1;        pts[7] = lim;
            pts[8] = {$urandom(), $urandom()};
            for (int p = 0; p < 9; p++) probe("R9 R10 random", pts[p], b, h, lim);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule